// File: doc/BRIEF.md
# Register-Addressed Block Transfer Controller

This block runs whole read and write transactions for a two-wire serial bus. It works one level above a byte-level bus engine. One request names the direction, a 7-bit device address, a one-byte register offset and a byte count. The controller then issues the right series of byte commands to the engine: START, write a byte, read a byte with ACK or NACK, and STOP. It moves the payload through a byte stream on each side. Page boundaries inside the device are left to the requester.

In normal mode, a read first writes the offset. It then turns the bus around with a repeated START, after an idle gap, and reads the data. A write is split into short chunks. After each chunk the controller polls the device with a read address until the device acknowledges, which tells it the internal write has finished. It then reads one throw-away byte and continues. A legacy mode serves older parts that take the offset in place of the device address and have no separate offset byte.

The engine handshake works like this. `cmd_valid_o` holds one command steady until the engine pulses `eng_done_i` for one cycle. With that pulse the engine returns `eng_ack_i` (the result of a write) or `eng_rdata_i` (the byte that was read). The controller moves to its next command on that same clock edge.

Top module: `blk_xfer_ctrl`

## Requirements
- R1: A normal-mode read issues these commands in order: START, WRITE {dev,0}, WRITE offset, then at least GAP_CYCLES cycles with `cmd_valid_o` low, then START, WRITE {dev,1}, then the reads. No STOP comes before the reads. The codes on `cmd_op_o` are START=0, WRITE=1, READ=2 and STOP=3.
- R2: A legacy-mode read issues START, then WRITE {offset[6:0],1} as its only address byte, then the reads.
- R3: Every read command carries `cmd_last_o`=0 (ACK) except the last byte of the request, which carries 1 (NACK) and is followed by STOP. Each byte read appears on `rd_data_o` with a one-cycle `rd_valid_o` pulse, one cycle after the engine completes the read.
- R4: A NACK on an address byte or an offset byte is followed at once by STOP. The request then ends with `done_o` and `err_o`=1.
- R5: A write issues chunks of at most CHUNK data bytes. Each chunk is START, WRITE {dev,0}, WRITE offset, the data bytes, then STOP. The offset of each following chunk is larger by the size of the chunk before it. `wr_pop_o` pulses once for each data byte consumed.
- R6: A legacy-mode write uses WRITE {offset[6:0],0} as its address byte and sends no offset byte.
- R7: After each chunk's STOP, the controller repeats START and WRITE {dev,1}, with a STOP after every NACK. When the MAX_POLLS-th attempt in a row is NACKed, the controller sends STOP and ends the request with `err_o`=1.
- R8: Once a poll is ACKed, the controller issues one READ with `cmd_last_o`=1, then STOP. It then starts the next chunk, or finishes without error.
- R9: A NACK on a data byte is followed at once by STOP and an error completion. This holds even when that byte is the last byte of a chunk: no poll follows.
- R10: A request with length 0 sets `done_o` one cycle after it is accepted, with `err_o`=0 and no command issued.
- R11: After reset `busy_o`, `done_o`, `err_o` and `cmd_valid_o` are all 0. `done_o` is a one-cycle pulse. `err_o` keeps its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_legacy_i | input | 1 | 1 = legacy addressing |
| req_dev_i | input | 7 | Device address |
| req_off_i | input | 8 | Register offset |
| req_len_i | input | LEN_W | Byte count |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | The last request failed |
| wr_data_i | input | 8 | Next byte to write (first-word-fall-through source) |
| wr_pop_o | output | 1 | Write byte consumed |
| rd_data_o | output | 8 | Byte read |
| rd_valid_o | output | 1 | `rd_data_o` is valid |
| cmd_valid_o | output | 1 | A command to the engine is pending |
| cmd_op_o | output | 2 | Command code: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data_o | output | 8 | Byte for a WRITE command |
| cmd_last_o | output | 1 | A READ ends with NACK |
| eng_done_i | input | 1 | Engine finished the current command |
| eng_ack_i | input | 1 | A written byte was ACKed |
| eng_rdata_i | input | 8 | Byte returned by a READ |

## Verification
Two functions can fall in the same cycle. A data NACK can arrive on the very completion that also closes a chunk, because it is the fourth byte. Chunk closing would lead to a poll, while the NACK must lead to an abort. The bench provokes this with a four-byte write whose engine model NACKs the fourth data byte. It passes only if exactly one STOP follows that byte, no poll START appears, and the request ends with `err_o` set. It also checks that `err_o` then holds across idle cycles until a new request clears it.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_START, S_ADDR, S_OFF, S_GAP, S_RSTART, S_RADDR, S_RD,
    S_WR, S_WSTOP, S_PSTART, S_PADDR, S_PSTOP, S_DRD, S_DSTOP,
    S_ESTOP, S_ASTOP
  } seq_state_e;
endpackage

// File: rtl/bxc_gap_timer.sv
module bxc_gap_timer #(
  parameter int unsigned GAP_CYCLES = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LOAD;
    else if (!run_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/bxc_retry_ctr.sv
module bxc_retry_ctr #(
  parameter int unsigned MAX_TRIES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // high while the attempt in flight is the final one allowed
  assign last_o = (cnt_q == CNT_W'(MAX_TRIES - 1));
endmodule

// File: rtl/bxc_fsm.sv
module bxc_fsm
  import bxc_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned CHUNK = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             req_legacy_i,
  input  logic [6:0]       req_dev_i,
  input  logic [7:0]       req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  input  logic [7:0]       wr_data_i,
  output logic             wr_pop_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             cmd_valid_o,
  output bus_op_e          cmd_op_o,
  output logic [7:0]       cmd_data_o,
  output logic             cmd_last_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  logic [7:0]       eng_rdata_i,
  output logic             gap_run_o,
  input  logic             gap_exp_i,
  output logic             poll_clr_o,
  output logic             poll_inc_o,
  input  logic             poll_last_i
);
  localparam int unsigned CHUNK_W = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_state_e       state_q;
  logic             write_q, legacy_q, done_q, err_q, rd_valid_q;
  logic [6:0]       dev_q;
  logic [7:0]       off_q, rd_data_q;
  logic [LEN_W-1:0] rem_q;
  logic [CHUNK_W-1:0] chunk_q;
  logic             last_byte, chunk_end;

  assign last_byte = (rem_q == ONE);
  assign chunk_end = last_byte || (chunk_q == CHUNK_W'(CHUNK - 1));

  always_comb begin
    cmd_valid_o = 1'b1;
    cmd_op_o    = OP_START;
    cmd_data_o  = '0;
    cmd_last_o  = 1'b0;
    unique case (state_q)
      S_START, S_RSTART, S_PSTART: cmd_op_o = OP_START;
      S_ADDR: begin
        cmd_op_o   = OP_WRITE;
        cmd_data_o = legacy_q ? {off_q[6:0], ~write_q} : {dev_q, 1'b0};
      end
      S_OFF: begin
        cmd_op_o   = OP_WRITE;
        cmd_data_o = off_q;
      end
      S_RADDR, S_PADDR: begin
        cmd_op_o   = OP_WRITE;
        cmd_data_o = {dev_q, 1'b1};
      end
      S_WR: begin
        cmd_op_o   = OP_WRITE;
        cmd_data_o = wr_data_i;
      end
      S_RD: begin
        cmd_op_o   = OP_READ;
        cmd_last_o = last_byte;
      end
      S_DRD: begin
        cmd_op_o   = OP_READ;
        cmd_last_o = 1'b1;
      end
      S_WSTOP, S_PSTOP, S_DSTOP, S_ESTOP, S_ASTOP: cmd_op_o = OP_STOP;
      default: cmd_valid_o = 1'b0;
    endcase
  end

  assign wr_pop_o   = (state_q == S_WR) && eng_done_i;
  assign gap_run_o  = (state_q == S_GAP);
  assign poll_clr_o = (state_q == S_WSTOP);
  assign poll_inc_o = (state_q == S_PADDR) && eng_done_i && !eng_ack_i;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      write_q    <= 1'b0;
      legacy_q   <= 1'b0;
      dev_q      <= '0;
      off_q      <= '0;
      rem_q      <= '0;
      chunk_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          write_q  <= req_write_i;
          legacy_q <= req_legacy_i;
          dev_q    <= req_dev_i;
          off_q    <= req_off_i;
          rem_q    <= req_len_i;
          chunk_q  <= '0;
          err_q    <= 1'b0;
          if (req_len_i == '0) done_q  <= 1'b1;
          else                 state_q <= S_START;
        end
        S_GAP: if (gap_exp_i) state_q <= S_RSTART;
        default: if (eng_done_i) begin
          unique case (state_q)
            S_START:  state_q <= S_ADDR;
            S_ADDR: begin
              if (!eng_ack_i)    state_q <= S_ASTOP;
              else if (legacy_q) state_q <= write_q ? S_WR : S_RD;
              else               state_q <= S_OFF;
            end
            S_OFF: begin
              if (!eng_ack_i) state_q <= S_ASTOP;
              else            state_q <= write_q ? S_WR : S_GAP;
            end
            S_RSTART: state_q <= S_RADDR;
            S_RADDR:  state_q <= eng_ack_i ? S_RD : S_ASTOP;
            S_RD: begin
              rd_data_q  <= eng_rdata_i;
              rd_valid_q <= 1'b1;
              rem_q      <= rem_q - ONE;
              if (last_byte) state_q <= S_ESTOP;
            end
            S_WR: begin
              // a NACK wins over chunk closing
              if (!eng_ack_i) state_q <= S_ASTOP;
              else begin
                rem_q   <= rem_q - ONE;
                off_q   <= off_q + 8'd1;
                chunk_q <= chunk_q + CHUNK_W'(1);
                if (chunk_end) state_q <= S_WSTOP;
              end
            end
            S_WSTOP: begin
              chunk_q <= '0;
              state_q <= S_PSTART;
            end
            S_PSTART: state_q <= S_PADDR;
            S_PADDR: begin
              if (eng_ack_i)        state_q <= S_DRD;
              else if (poll_last_i) state_q <= S_ASTOP;
              else                  state_q <= S_PSTOP;
            end
            S_PSTOP:  state_q <= S_PSTART;
            S_DRD:    state_q <= S_DSTOP;
            S_DSTOP: begin
              if (rem_q == '0) begin
                state_q <= S_IDLE;
                done_q  <= 1'b1;
              end else state_q <= S_START;
            end
            S_ESTOP: begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end
            S_ASTOP: begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
            end
            default: state_q <= S_IDLE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
  import bxc_pkg::*;
#(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned CHUNK      = 4,
  parameter int unsigned MAX_POLLS  = 100,
  parameter int unsigned GAP_CYCLES = 3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             req_legacy_i,
  input  logic [6:0]       req_dev_i,
  input  logic [7:0]       req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  input  logic [7:0]       wr_data_i,
  output logic             wr_pop_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [7:0]       cmd_data_o,
  output logic             cmd_last_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  logic [7:0]       eng_rdata_i
);
  bus_op_e op;
  logic    gap_run, gap_exp, poll_clr, poll_inc, poll_last;

  assign cmd_op_o = op;

  bxc_fsm #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_legacy_i,
    .req_dev_i, .req_off_i, .req_len_i, .busy_o, .done_o, .err_o,
    .wr_data_i, .wr_pop_o, .rd_data_o, .rd_valid_o, .cmd_valid_o,
    .cmd_op_o(op), .cmd_data_o, .cmd_last_o, .eng_done_i, .eng_ack_i,
    .eng_rdata_i, .gap_run_o(gap_run), .gap_exp_i(gap_exp),
    .poll_clr_o(poll_clr), .poll_inc_o(poll_inc), .poll_last_i(poll_last)
  );

  bxc_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i, .rst_ni, .run_i(gap_run), .expired_o(gap_exp)
  );

  bxc_retry_ctr #(.MAX_TRIES(MAX_POLLS)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc), .last_o(poll_last)
  );
endmodule

// File: rtl/bxc_checker.sv
module bxc_checker #(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned CHUNK = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [LEN_W-1:0] req_len_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             wr_pop_o,
  input logic             rd_valid_o,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic             eng_done_i,
  input logic             eng_ack_i
);
  logic [7:0] pop_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_cnt <= '0;
    else if (cmd_valid_o && cmd_op_o == 2'd3 && eng_done_i) pop_cnt <= '0;
    else if (wr_pop_o) pop_cnt <= pop_cnt + 8'd1;
  end

  a_r10_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_len_i == '0) |=> (done_o && !err_o && !busy_o));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_valid_i) |=> $stable(err_o));

  a_r3_rd_from_engine: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_o && cmd_op_o == 2'd2 && eng_done_i));

  a_r5_chunk_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pop_o |-> (pop_cnt < 8'(CHUNK)));

  // R4, R7, R9: every NACKed write is followed by STOP
  a_r4_nack_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd1 && eng_done_i && !eng_ack_i)
      |=> (cmd_valid_o && cmd_op_o == 2'd3));
endmodule

bind blk_xfer_ctrl bxc_checker #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_len_i(req_len_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .wr_pop_o(wr_pop_o), .rd_valid_o(rd_valid_o), .cmd_valid_o(cmd_valid_o),
  .cmd_op_o(cmd_op_o), .eng_done_i(eng_done_i), .eng_ack_i(eng_ack_i)
);

// File: tb/sim_blk_xfer_ctrl.sv
module sim_blk_xfer_ctrl;
  localparam int GAP = 6;
  localparam int MAXP = 5;
  localparam logic [1:0] ST = 2'd0, WR = 2'd1, RD = 2'd2, SP = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid_i = 0, req_write_i = 0, req_legacy_i = 0;
  logic [6:0] req_dev_i = '0;
  logic [7:0] req_off_i = '0, req_len_i = '0;
  logic busy_o, done_o, err_o, wr_pop_o, rd_valid_o, cmd_valid_o, cmd_last_o;
  logic [7:0] wr_data_i, rd_data_o, cmd_data_o;
  logic [1:0] cmd_op_o;
  logic eng_done_i = 0, eng_ack_i = 0;
  logic [7:0] eng_rdata_i = '0;

  logic [10:0] log_q [0:255];
  int          stamp_q [0:255];
  logic [10:0] exp_q [0:255];
  logic [7:0]  rbuf [0:63];
  logic [7:0]  wbuf [0:63];
  int log_n = 0, exp_n = 0, rd_n = 0, widx = 0, rcnt = 0, ncyc = 0;
  int nack_idx = -1, poll_left = 0, pp1 = -1, pp2 = -1;
  logic [6:0] cur_dev = '0;
  int checks = 0, fails = 0;

  assign wr_data_i = wbuf[widx[5:0]];

  blk_xfer_ctrl #(.LEN_W(8), .CHUNK(4), .MAX_POLLS(MAXP), .GAP_CYCLES(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i, .req_write_i, .req_legacy_i,
    .req_dev_i, .req_off_i, .req_len_i, .busy_o, .done_o, .err_o,
    .wr_data_i, .wr_pop_o, .rd_data_o, .rd_valid_o, .cmd_valid_o, .cmd_op_o,
    .cmd_data_o, .cmd_last_o, .eng_done_i, .eng_ack_i, .eng_rdata_i
  );

  initial forever #10 clk = ~clk;
  initial forever begin @(posedge clk); ncyc++; end
  initial forever begin @(posedge clk); if (wr_pop_o) widx++; end
  initial forever begin
    @(negedge clk);
    if (rd_valid_o && rd_n < 64) begin rbuf[rd_n] = rd_data_o; rd_n++; end
  end

  function automatic logic [10:0] ent(logic [1:0] op, logic [7:0] d, logic l);
    return {op, (op == RD) ? l : 1'b0, (op == WR) ? d : 8'h00};
  endfunction

  // byte engine and device model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid_o) begin
        logic [1:0] op;
        logic ack, poll;
        op   = cmd_op_o;
        poll = (op == WR) && (cmd_data_o == {cur_dev, 1'b1}) && pp1 == ST && pp2 == SP;
        ack  = (log_n != nack_idx);
        if (poll && poll_left > 0) begin ack = 1'b0; poll_left--; end
        if (log_n < 256) begin
          log_q[log_n]   = ent(op, cmd_data_o, cmd_last_o);
          stamp_q[log_n] = ncyc;
        end
        log_n++;
        pp2 = pp1; pp1 = op;
        repeat (2) @(negedge clk);
        eng_ack_i   = ack;
        eng_rdata_i = 8'hC0 + 8'(rcnt);
        if (op == RD) rcnt++;
        eng_done_i  = 1'b1;
        @(negedge clk);
        eng_done_i  = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic exp_add(input logic [1:0] op, input logic [7:0] d, input logic l);
    exp_q[exp_n] = ent(op, d, l);
    exp_n++;
  endtask

  task automatic check_log(input string tag);
    int bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && log_q[i] !== exp_q[i]) bad = i;
    if (bad < 0 && log_n != exp_n) bad = (log_n < exp_n) ? log_n : exp_n;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else if (bad < log_n && bad < exp_n)
      check(1'b0, {tag, " cmd seq"}, int'(log_q[bad]), int'(exp_q[bad]));
    else check(1'b0, {tag, " cmd count"}, log_n, exp_n);
  endtask

  task automatic run_req(input logic wr, input logic lg, input logic [6:0] dv,
                         input logic [7:0] of, input int ln, input int nk,
                         input int pn, output int waited);
    log_n = 0; exp_n = 0; rd_n = 0; widx = 0; rcnt = 0; pp1 = -1; pp2 = -1;
    cur_dev = dv; nack_idx = nk; poll_left = pn;
    @(negedge clk);
    req_write_i = wr; req_legacy_i = lg; req_dev_i = dv; req_off_i = of;
    req_len_i = 8'(ln); req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 5000) begin @(negedge clk); waited++; end
  endtask

  task automatic exp_write(input logic lg, input logic [6:0] dv, input logic [7:0] of,
                           input int ln, input int pn);
    int rem = ln, k = 0, first = 1;
    logic [7:0] o = of;
    while (rem > 0) begin
      int n = (rem < 4) ? rem : 4;
      exp_add(ST, 0, 0);
      exp_add(WR, lg ? {o[6:0], 1'b0} : {dv, 1'b0}, 0);
      if (!lg) exp_add(WR, o, 0);
      for (int i = 0; i < n; i++) begin exp_add(WR, wbuf[k], 0); k++; end
      exp_add(SP, 0, 0);
      for (int j = 0; j < (first ? pn : 0); j++) begin
        exp_add(ST, 0, 0); exp_add(WR, {dv, 1'b1}, 0); exp_add(SP, 0, 0);
      end
      exp_add(ST, 0, 0); exp_add(WR, {dv, 1'b1}, 0); exp_add(RD, 0, 1); exp_add(SP, 0, 0);
      o = o + 8'(n); rem -= n; first = 0;
    end
  endtask

  task automatic t_reset();
    check(!busy_o, "R11 busy after reset", busy_o, 0);
    check(!done_o, "R11 done after reset", done_o, 0);
    check(!err_o, "R11 err after reset", err_o, 0);
    check(!cmd_valid_o, "R11 cmd_valid after reset", cmd_valid_o, 0);
  endtask

  task automatic t_zero_len();
    int w;
    run_req(1'b1, 1'b0, 7'h50, 8'h00, 0, -1, 0, w);
    check(w == 0 && done_o, "R10 done timing", w, 0);
    check(log_n == 0, "R10 no commands", log_n, 0);
    check(!err_o, "R10 err", err_o, 0);
  endtask

  task automatic t_read_normal();
    int w;
    run_req(1'b0, 1'b0, 7'h50, 8'h10, 3, -1, 0, w);
    exp_add(ST, 0, 0); exp_add(WR, 8'hA0, 0); exp_add(WR, 8'h10, 0);
    exp_add(ST, 0, 0); exp_add(WR, 8'hA1, 0);
    exp_add(RD, 0, 0); exp_add(RD, 0, 0); exp_add(RD, 0, 1); exp_add(SP, 0, 0);
    check_log("R1 R3 normal read");
    check(stamp_q[3] - stamp_q[2] >= GAP + 3, "R1 gap before repeated start",
          stamp_q[3] - stamp_q[2], GAP + 3);
    check(rd_n == 3, "R3 byte count", rd_n, 3);
    for (int i = 0; i < 3; i++)
      check(rbuf[i] == 8'hC0 + 8'(i), "R3 read data", rbuf[i], 8'hC0 + i);
    check(!err_o, "R3 no error", err_o, 0);
  endtask

  task automatic t_read_legacy();
    int w;
    run_req(1'b0, 1'b1, 7'h50, 8'h25, 2, -1, 0, w);
    exp_add(ST, 0, 0); exp_add(WR, 8'h4B, 0);
    exp_add(RD, 0, 0); exp_add(RD, 0, 1); exp_add(SP, 0, 0);
    check_log("R2 legacy read");
    check(rd_n == 2 && rbuf[1] == 8'hC1, "R2 legacy data", rbuf[1], 8'hC1);
  endtask

  task automatic t_read_nack();
    int w;
    run_req(1'b0, 1'b0, 7'h50, 8'h10, 3, 2, 0, w);
    exp_add(ST, 0, 0); exp_add(WR, 8'hA0, 0); exp_add(WR, 8'h10, 0); exp_add(SP, 0, 0);
    check_log("R4 offset nack");
    check(err_o, "R4 error flag", err_o, 1);
    check(rd_n == 0, "R4 no data", rd_n, 0);
  endtask

  task automatic t_write_normal();
    int w;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'h11 + 8'(i);
    run_req(1'b1, 1'b0, 7'h50, 8'h20, 6, -1, 0, w);
    exp_write(1'b0, 7'h50, 8'h20, 6, 0);
    check_log("R5 R8 chunked write");
    check(widx == 6, "R5 pops", widx, 6);
    check(!err_o, "R8 no error", err_o, 0);
  endtask

  task automatic t_write_legacy();
    int w;
    run_req(1'b1, 1'b1, 7'h33, 8'h08, 5, -1, 0, w);
    exp_write(1'b1, 7'h33, 8'h08, 5, 0);
    check_log("R6 legacy write");
    check(!err_o, "R6 no error", err_o, 0);
  endtask

  task automatic t_poll_retry();
    int w;
    run_req(1'b1, 1'b0, 7'h50, 8'h40, 1, -1, 3, w);
    exp_write(1'b0, 7'h50, 8'h40, 1, 3);
    check_log("R7 poll retries");
    check(!err_o, "R7 no error after retries", err_o, 0);
  endtask

  task automatic t_poll_exhaust();
    int w;
    run_req(1'b1, 1'b0, 7'h50, 8'h40, 1, -1, 99, w);
    exp_add(ST, 0, 0); exp_add(WR, 8'hA0, 0); exp_add(WR, 8'h40, 0);
    exp_add(WR, wbuf[0], 0); exp_add(SP, 0, 0);
    for (int j = 0; j < MAXP; j++) begin
      exp_add(ST, 0, 0); exp_add(WR, 8'hA1, 0); exp_add(SP, 0, 0);
    end
    check_log("R7 poll exhausted");
    check(err_o, "R7 exhaust error", err_o, 1);
  endtask

  task automatic t_data_nack();
    int w;
    run_req(1'b1, 1'b0, 7'h50, 8'h00, 4, 6, 0, w);
    exp_add(ST, 0, 0); exp_add(WR, 8'hA0, 0); exp_add(WR, 8'h00, 0);
    for (int i = 0; i < 4; i++) exp_add(WR, wbuf[i], 0);
    exp_add(SP, 0, 0);
    check_log("R9 nack on chunk end byte");
    check(err_o, "R9 error flag", err_o, 1);
    repeat (10) @(negedge clk);
    check(err_o && !done_o, "R11 err held while idle", err_o, 1);
    run_req(1'b0, 1'b0, 7'h50, 8'h00, 0, -1, 0, w);
    check(!err_o, "R11 err cleared by new request", err_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_zero_len();
    t_read_normal();
    t_read_legacy();
    t_read_nack();
    t_write_normal();
    t_write_legacy();
    t_poll_retry();
    t_poll_exhaust();
    t_data_nack();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule